// File: doc/BRIEF.md
# Address-Based Security Attribution Unit

This block gives security attributes for any 32-bit physical address in a microcontroller that can run secure and non-secure code. The attributes come from fixed rules on the address bits. The top four address bits form a region number. The lowest bit of that number selects secure or non-secure. Two small address windows near the top of the map are marked exempt from attribution checks.

A two-bit configuration register lets software mark two of the secure regions as callable from non-secure code: region 1 and region 3, each with its own enable bit. The register has a plain write strobe with a 32-bit data word and a 32-bit read-back port. All attribute outputs are combinational from the address and the current register contents.

Top module: `sec_attr_unit`

## Requirements
- R1: `region_id` equals `addr[31:28]`.
- R2: `nonsecure` is 1 exactly when `addr[28]` is 0.
- R3: when `addr[31:28]` is 4'd1, `ns_callable` equals configuration bit 0.
- R4: when `addr[31:28]` is 4'd3, `ns_callable` equals configuration bit 1.
- R5: for any region other than 1 and 3, `ns_callable` is 0 whatever the configuration bits hold.
- R6: `exempt` is 1 exactly when `(addr & 32'hEFF0_0000) == 32'hE000_0000`, so for 0xE0000000..0xE00FFFFF and 0xF0000000..0xF00FFFFF only.
- R7: after reset the configuration register is 0: `cfg_rdata` reads 0 and no region is callable.
- R8: on a rising clock edge with `cfg_we` high, the register takes `cfg_wdata[1:0]` (bit 0 enables region 1, bit 1 enables region 3), and `cfg_wdata[31:2]` has no effect. With `cfg_we` low the register holds its value.
- R9: `cfg_rdata` returns the register in bits [1:0], and bits [31:2] are always 0.
- R10: the attribute outputs follow `addr` with no clock edge in between. They reflect a register write from the edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data; only bits [1:0] are used |
| cfg_rdata | output | 32 | Configuration read-back, zero-extended |
| addr | input | 32 | Physical address being attributed |
| region_id | output | 4 | Region number of the address |
| nonsecure | output | 1 | Address lies in a non-secure region |
| ns_callable | output | 1 | Address lies in a secure region that non-secure code may call |
| exempt | output | 1 | Address is exempt from attribution checks |

## Verification
All four attributes are due in the same cycle as the address. The bench drives each address on a falling edge and samples one nanosecond later, before any rising edge. A configuration write takes effect on the rising edge that samples the strobe. The bench checks the read-back and the callable attribute on the following falling edge, half a cycle later. The internal reset release adds two cycles, so the bench leaves several cycles after reset before its first write.

// File: rtl/sau_pkg.sv
package sau_pkg;

  localparam int ADDR_W   = 32;
  localparam int REGION_W = 4;
  localparam int CFG_W    = 2;
  localparam int DATA_W   = 32;

  // exemption window: compare selected upper bits against a fixed pattern
  localparam logic [ADDR_W-1:0] EXEMPT_MASK  = 32'hEFF0_0000;
  localparam logic [ADDR_W-1:0] EXEMPT_MATCH = 32'hE000_0000;

  typedef struct packed {
    logic [REGION_W-1:0] region;
    logic                ns;
    logic                nsc;
    logic                exempt;
  } sau_attr_t;

endpackage

// File: rtl/sau_rst_sync.sv
module sau_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/sau_cfg_reg.sv
module sau_cfg_reg #(
  parameter int CFG_W  = sau_pkg::CFG_W,
  parameter int DATA_W = sau_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [CFG_W-1:0]  cfg,
  output logic [DATA_W-1:0] rdata
);

  localparam int PAD_W = DATA_W - CFG_W;

  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;
  logic             cfg_en;
  logic             unused_wdata_hi;

  always_comb begin
    cfg_en = we;
    cfg_d  = wdata[CFG_W-1:0];
  end

  assign unused_wdata_hi = ^wdata[DATA_W-1:CFG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign cfg   = cfg_q;
  assign rdata = {{PAD_W{1'b0}}, cfg_q};

  // R8
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg == $past(wdata[CFG_W-1:0])));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg));

endmodule

// File: rtl/sau_region_decode.sv
module sau_region_decode #(
  parameter int ADDR_W   = sau_pkg::ADDR_W,
  parameter int REGION_W = sau_pkg::REGION_W
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [REGION_W-1:0] region,
  output logic                ns,
  output logic                exempt
);

  always_comb begin
    region = addr[ADDR_W-1 -: REGION_W];
    ns     = ~region[0];
    exempt = ((addr & sau_pkg::EXEMPT_MASK) == sau_pkg::EXEMPT_MATCH);
  end

endmodule

// File: rtl/sau_callable.sv
module sau_callable #(
  parameter int REGION_W = sau_pkg::REGION_W,
  parameter int CFG_W    = sau_pkg::CFG_W
) (
  input  logic [REGION_W-1:0] region,
  input  logic [CFG_W-1:0]    cfg,
  output logic                nsc
);

  logic [CFG_W-1:0] hit;

  // enable bit i governs odd (secure) region 2*i+1
  for (genvar i = 0; i < CFG_W; i++) begin : g_slot
    localparam logic [REGION_W-1:0] SLOT_REGION = REGION_W'(2 * i + 1);
    assign hit[i] = (region == SLOT_REGION) & cfg[i];
  end

  assign nsc = |hit;

endmodule

// File: rtl/sec_attr_unit.sv
module sec_attr_unit #(
  parameter int ADDR_W   = sau_pkg::ADDR_W,
  parameter int REGION_W = sau_pkg::REGION_W,
  parameter int CFG_W    = sau_pkg::CFG_W,
  parameter int DATA_W   = sau_pkg::DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic [DATA_W-1:0]   cfg_rdata,
  input  logic [ADDR_W-1:0]   addr,
  output logic [REGION_W-1:0] region_id,
  output logic                nonsecure,
  output logic                ns_callable,
  output logic                exempt
);

  import sau_pkg::*;

  logic             rst_n_sync;
  logic [CFG_W-1:0] cfg;
  sau_attr_t        attr;

  sau_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  sau_cfg_reg #(.CFG_W(CFG_W), .DATA_W(DATA_W)) u_cfg_reg (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  sau_region_decode #(.ADDR_W(ADDR_W), .REGION_W(REGION_W)) u_decode (
    .addr   (addr),
    .region (attr.region),
    .ns     (attr.ns),
    .exempt (attr.exempt)
  );

  sau_callable #(.REGION_W(REGION_W), .CFG_W(CFG_W)) u_callable (
    .region (attr.region),
    .cfg    (cfg),
    .nsc    (attr.nsc)
  );

  assign region_id   = attr.region;
  assign nonsecure   = attr.ns;
  assign ns_callable = attr.nsc;
  assign exempt      = attr.exempt;

  // R5
  nsc_region_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ns_callable |-> (region_id == REGION_W'(1) || region_id == REGION_W'(3)));

  // R2
  nsc_secure_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ns_callable |-> !nonsecure);

  // R6
  exempt_top_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    exempt |-> (addr[ADDR_W-1 -: 3] == 3'b111));

  // R9
  rdata_pad_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    cfg_rdata[DATA_W-1:CFG_W] == '0);

  // R7
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(rst_n_sync) |-> (cfg_rdata == '0));

endmodule

// File: tb/test_sec_attr_unit.sv
`timescale 1ns/1ps
module test_sec_attr_unit;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [31:0] addr;
  logic [3:0]  region_id;
  logic        nonsecure;
  logic        ns_callable;
  logic        exempt;

  int   checks;
  int   failures;
  bit   done;
  logic [1:0] mcfg;

  sec_attr_unit i_sec_attr_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .addr(addr), .region_id(region_id),
    .nonsecure(nonsecure), .ns_callable(ns_callable), .exempt(exempt)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic exp_ns(logic [31:0] a);
    return ~a[28];
  endfunction

  function automatic logic exp_nsc(logic [31:0] a, logic [1:0] c);
    if (a[31:28] == 4'd1) return c[0];
    if (a[31:28] == 4'd3) return c[1];
    return 1'b0;
  endfunction

  function automatic logic exp_exempt(logic [31:0] a);
    return (a[31:20] == 12'hE00) || (a[31:20] == 12'hF00);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R1 R2 R6 and R3/R4/R5 by region; R10: checked 1 ns after the change
  task automatic apply_addr(logic [31:0] a);
    string ctag;
    @(negedge clk);
    addr = a;
    #1;
    ctag = (a[31:28] == 4'd1) ? "R3" : (a[31:28] == 4'd3) ? "R4" : "R5";
    chk("R1 region", 32'(region_id), 32'(a[31:28]));
    chk("R2 nonsecure", 32'(nonsecure), 32'(exp_ns(a)));
    chk({ctag, " callable"}, 32'(ns_callable), 32'(exp_nsc(a, mcfg)));
    chk("R6 exempt", 32'(exempt), 32'(exp_exempt(a)));
  endtask

  // R8 write, R9 read-back, R10 callable follows from write edge
  task automatic write_cfg(logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_wdata = ~d;
    mcfg = d[1:0];
    #1;
    chk("R8 write", cfg_rdata, {30'd0, d[1:0]});
    addr = 32'h1000_0000;
    #1;
    chk("R10 callable r1 after write", 32'(ns_callable), 32'(mcfg[0]));
    addr = 32'h3000_0000;
    #1;
    chk("R10 callable r3 after write", 32'(ns_callable), 32'(mcfg[1]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 0; mcfg = 2'b00;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7 reset state
    #1;
    chk("R7 reset rdata", cfg_rdata, 32'd0);
    addr = 32'h1000_0040;
    #1;
    chk("R7 reset r1 not callable", 32'(ns_callable), 32'd0);
    addr = 32'h3FFF_FFFF;
    #1;
    chk("R7 reset r3 not callable", 32'(ns_callable), 32'd0);

    // R6 exemption edges
    apply_addr(32'hE000_0000);
    apply_addr(32'hE00F_FFFF);
    apply_addr(32'hE010_0000);
    apply_addr(32'hDFFF_FFFF);
    apply_addr(32'hF000_0000);
    apply_addr(32'hF00F_FFFF);
    apply_addr(32'hF010_0000);
    apply_addr(32'hF100_0000);

    // R8: upper bits ignored, R9 zero-extended read-back
    write_cfg(32'hFFFF_FFFD);
    chk("R9 pad zero", {2'b00, cfg_rdata[31:2]}, 32'd0);
    apply_addr(32'h1234_5678);
    apply_addr(32'h3000_0000);
    write_cfg(32'hA5A5_A5A6);
    apply_addr(32'h1FFF_FFFF);
    apply_addr(32'h3ABC_DEF0);

    // R5: both enabled, other odd and even regions stay clear
    write_cfg(32'h0000_0003);
    for (int r = 0; r < 16; r++) apply_addr({4'(r), 28'h0ABCDEF});

    // R8 hold: strobe low with changing data
    @(negedge clk);
    cfg_wdata = 32'h0000_0000;
    @(negedge clk);
    cfg_wdata = 32'hFFFF_FFFE;
    @(negedge clk);
    #1;
    chk("R8 hold when strobe low", cfg_rdata, 32'h0000_0003);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      if ((i % 64) == 0) write_cfg($urandom);
      a = $urandom;
      case ($urandom_range(0, 3))
        0: a[31:28] = 4'd1;
        1: a[31:28] = 4'd3;
        2: a[31:20] = ($urandom_range(0, 1) == 1) ? 12'hE00 : 12'hF00;
        default: ;
      endcase
      apply_addr(a);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule